// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address. It reads the mapping from a two-level translation table in memory. A walk starts with a one-cycle `start` pulse. First the address is moved into the current process's window: an address below a fixed limit has the process offset added to it. The walker then fetches the first-level descriptor through a single-word read port. If that descriptor points to a coarse or a fine second-level table, the walker fetches one more word. It never has more than one read in flight.

When the walk finishes, `done` pulses for one cycle. In that cycle the block presents the page kind, the physical address, the 4-bit domain, the 2-bit access field that applies to the addressed part of the page, and the tag bits a translation cache would store. Permission checking is done by a separate checker. That checker looks at the domain, access and kind outputs and returns a status byte, which the walker samples during `done`.

The block keeps two registers for data-side walks: a fault status and a fault address. They change only when a data walk completes with a fault, and the new values appear the cycle after `done`. Instruction-fetch walks report failure through `ok` alone and leave both registers unchanged.

Top module: `xlat_table_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req` are 0, and `fault_status` and `fault_addr` are 0.
- R2: A virtual address below 0x0200_0000 has `pid_offset` added to it (modulo 2^32) before any other use. Every later address, tag and fault address is derived from this effective address. Addresses at or above the limit are used unchanged.
- R3: The first read goes to {table_base[31:14], va[31:20], 2'b00}. `mem_req` is high for exactly one cycle per read. The next request is issued only after the previous response has been taken, so a walk makes one read, or two reads when a second-level table is involved.
- R4: First-level bits [1:0] mean: 0 unmapped, 1 coarse table, 2 section, 3 fine table. A section completes after one read with kind code 0, paddr {d1[31:20], va[19:0]}, access d1[11:10] and tag {va[31:20], 20'h0}. The domain is always d1[8:5].
- R5: The second read goes to {d1[31:10], va[19:12], 2'b00} for a coarse table and to {d1[31:12], va[19:10], 2'b00} for a fine table.
- R6: Second-level bits [1:0] mean: 0 unmapped, 1 large page, 2 small page, 3 tiny page. The kind codes are 1, 2 and 3. The physical addresses are {d2[31:16], va[15:0]}, {d2[31:12], va[11:0]} and {d2[31:10], va[9:0]}. The tag is {va[31:12], 12'h0} for large and small pages and {va[31:10], 10'h0} for tiny pages.
- R7: The access field of a large page is d2 bits [5+2k:4+2k] with k = va[15:14]. For a small page k = va[11:10]. A tiny page always uses d2[5:4].
- R8: A tiny-page descriptor reached through a coarse table ends the walk with `ok` = 0 and leaves the fault registers unchanged.
- R9: On a data walk, an unmapped first-level entry sets `fault_status` to 0x05. An unmapped second-level entry sets it to {d1[8:5], 4'h7}. In both cases `fault_addr` takes the effective virtual address, and both registers show the new values the cycle after `done`.
- R10: `perm_status` is sampled while `done` is high. A nonzero value after a successful translation forces `ok` to 0. On a data walk that value is also copied into `fault_status`, and the effective address into `fault_addr`.
- R11: An instruction-fetch walk (`is_fetch` = 1) never changes `fault_status` or `fault_addr`, whatever the outcome.
- R12: `done` is high for exactly one cycle per walk. A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| is_fetch | input | 1 | 1 for an instruction-fetch walk, 0 for a data walk |
| table_base | input | 32 | First-level table base (bits [31:14] used) |
| pid_offset | input | 32 | Process offset added to low addresses |
| perm_status | input | 8 | Status from the external permission checker, 0 = allowed |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 32 | Descriptor address, valid with `mem_req` |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| ok | output | 1 | Translation succeeded and permitted (valid with `done`) |
| page_kind | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| paddr | output | 32 | Physical address |
| domain | output | 4 | Domain of the mapping |
| access | output | 2 | Access field selected for the address |
| tag | output | 32 | Virtual address with the in-page bits cleared |
| fault_status | output | 8 | Last data-side fault status |
| fault_addr | output | 32 | Last data-side faulting effective address |

## Verification
Some properties are checked by assertions on every cycle. `done` and `mem_req` never last longer than one cycle. A start request is followed by a read. A `start` pulse during a walk leaves the captured address alone. The fault registers stay still except after a data walk completes. A successful result keeps the virtual page bits in its tag and the in-page offset in its physical address. Other behaviour can only be shown by bench scenarios with known table contents: the descriptor addresses, the subpage access selection, the process-offset window, the coarse-table rejection of tiny pages, and the exact fault codes.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W   = 32;
    localparam int DOM_W  = 4;
    localparam int AP_W   = 2;
    localparam int FS_W   = 8;
    localparam int SUBPG  = 4;
    localparam int AP_LO  = 4;

    localparam int SECT_LO  = 20;
    localparam int LARGE_LO = 16;
    localparam int SMALL_LO = 12;
    localparam int TINY_LO  = 10;

    typedef logic [VA_W-1:0] word_t;

    typedef enum logic [2:0] {
        W_IDLE, W_L1_REQ, W_L1_WAIT, W_L2_REQ, W_L2_WAIT, W_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_TINY    = 2'd3
    } page_kind_t;

    localparam logic [1:0] L1_NONE   = 2'd0;
    localparam logic [1:0] L1_COARSE = 2'd1;
    localparam logic [1:0] L1_SECT   = 2'd2;
    localparam logic [1:0] L1_FINE   = 2'd3;

    localparam logic [1:0] L2_NONE  = 2'd0;
    localparam logic [1:0] L2_LARGE = 2'd1;
    localparam logic [1:0] L2_SMALL = 2'd2;
    localparam logic [1:0] L2_TINY  = 2'd3;

    localparam logic [3:0] FC_MISS_L1 = 4'd5;
    localparam logic [3:0] FC_MISS_L2 = 4'd7;

    typedef struct packed {
        logic              ok;
        logic              need_l2;
        logic              fvalid;
        logic [FS_W-1:0]   fstat;
        page_kind_t        kind;
        word_t             paddr;
        logic [DOM_W-1:0]  domain;
        logic [AP_W-1:0]   access;
        word_t             tag;
    } walk_res_t;

    // Mask with ones from bit lo upwards
    function automatic word_t upper_mask(int unsigned lo);
        word_t m;
        m = {VA_W{1'b1}} << lo;
        return m;
    endfunction

    // Frame bits from a descriptor, offset bits from the address
    function automatic word_t splice(word_t frame, word_t va, int unsigned lo);
        return (frame & upper_mask(lo)) | (va & ~upper_mask(lo));
    endfunction

    function automatic word_t page_tag(word_t va, int unsigned lo);
        return va & upper_mask(lo);
    endfunction

    function automatic word_t l1_slot(word_t base, word_t va);
        return {base[31:14], va[31:20], 2'b00};
    endfunction

    function automatic word_t l2_slot(word_t d1, word_t va);
        if (d1[1:0] == L1_COARSE)
            return {d1[31:10], va[19:12], 2'b00};
        return {d1[31:12], va[19:10], 2'b00};
    endfunction

endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen
    import xlat_pkg::*;
(
    input  walk_state_t state,
    input  word_t       base,
    input  word_t       va,
    input  word_t       d1,
    output word_t       addr
);

    always_comb begin
        if (state == W_L2_REQ || state == W_L2_WAIT)
            addr = l2_slot(d1, va);
        else
            addr = l1_slot(base, va);
    end

endmodule

// File: rtl/xlat_desc_decode.sv
module xlat_desc_decode
    import xlat_pkg::*;
(
    input  word_t     va,
    input  word_t     d1,
    input  word_t     d2,
    input  logic      at_l2,
    output walk_res_t res
);

    logic [AP_W-1:0]  sub_ap [SUBPG];
    logic [DOM_W-1:0] dom;

    assign dom = d1[8:5];

    for (genvar g = 0; g < SUBPG; g++) begin : g_sub
        assign sub_ap[g] = d2[AP_LO + AP_W*g +: AP_W];
    end

    always_comb begin
        res        = '0;
        res.domain = dom;
        if (!at_l2) begin
            unique case (d1[1:0])
                L1_NONE: begin
                    res.fvalid = 1'b1;
                    res.fstat  = {4'h0, FC_MISS_L1};
                end
                L1_SECT: begin
                    res.ok     = 1'b1;
                    res.kind   = PG_SECTION;
                    res.paddr  = splice(d1, va, SECT_LO);
                    res.access = d1[11:10];
                    res.tag    = page_tag(va, SECT_LO);
                end
                default: res.need_l2 = 1'b1;
            endcase
        end else begin
            unique case (d2[1:0])
                L2_NONE: begin
                    res.fvalid = 1'b1;
                    res.fstat  = {dom, FC_MISS_L2};
                end
                L2_LARGE: begin
                    res.ok     = 1'b1;
                    res.kind   = PG_LARGE;
                    res.paddr  = splice(d2, va, LARGE_LO);
                    res.access = sub_ap[va[15:14]];
                    res.tag    = page_tag(va, SMALL_LO);
                end
                L2_SMALL: begin
                    res.ok     = 1'b1;
                    res.kind   = PG_SMALL;
                    res.paddr  = splice(d2, va, SMALL_LO);
                    res.access = sub_ap[va[11:10]];
                    res.tag    = page_tag(va, SMALL_LO);
                end
                default: begin
                    // tiny entries are legal only under a fine table
                    res.kind = PG_TINY;
                    if (d1[1:0] == L1_FINE) begin
                        res.ok     = 1'b1;
                        res.paddr  = splice(d2, va, TINY_LO);
                        res.access = sub_ap[0];
                        res.tag    = page_tag(va, TINY_LO);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/xlat_walk_ctrl.sv
module xlat_walk_ctrl
    import xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        rsp_valid,
    input  logic        need_l2,
    output walk_state_t state,
    output logic        mem_req,
    output logic        done,
    output logic        busy,
    output logic        cap_start,
    output logic        cap_l1,
    output logic        cap_res
);

    walk_state_t nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            W_IDLE:    if (start) nxt = W_L1_REQ;
            W_L1_REQ:  nxt = W_L1_WAIT;
            W_L1_WAIT: if (rsp_valid) nxt = need_l2 ? W_L2_REQ : W_DONE;
            W_L2_REQ:  nxt = W_L2_WAIT;
            W_L2_WAIT: if (rsp_valid) nxt = W_DONE;
            W_DONE:    nxt = W_IDLE;
            default:   nxt = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= W_IDLE;
        else     state <= nxt;
    end

    assign mem_req   = (state == W_L1_REQ) || (state == W_L2_REQ);
    assign done      = (state == W_DONE);
    assign busy      = (state != W_IDLE);
    assign cap_start = (state == W_IDLE) && start;
    assign cap_l1    = (state == W_L1_WAIT) && rsp_valid;
    assign cap_res   = ((state == W_L1_WAIT) && rsp_valid && !need_l2) ||
                       ((state == W_L2_WAIT) && rsp_valid);

    // R12
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R3
    start_read_chk: assert property (@(posedge clk) disable iff (rst)
        cap_start |=> mem_req);

endmodule

// File: rtl/xlat_table_walker.sv
module xlat_table_walker
    import xlat_pkg::*;
#(
    parameter logic [31:0] PID_WINDOW = 32'h0200_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [31:0] vaddr,
    input  logic        is_fetch,
    input  logic [31:0] table_base,
    input  logic [31:0] pid_offset,
    input  logic [7:0]  perm_status,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        busy,
    output logic        done,
    output logic        ok,
    output logic [1:0]  page_kind,
    output logic [31:0] paddr,
    output logic [3:0]  domain,
    output logic [1:0]  access,
    output logic [31:0] tag,
    output logic [7:0]  fault_status,
    output logic [31:0] fault_addr
);

    walk_state_t st;
    logic        cap_start, cap_l1, cap_res;
    word_t       va_q, base_q, d1_q, va_eff, d1_src;
    logic        fetch_q;
    walk_res_t   res_d, res_q;
    logic        perm_bad;

    assign va_eff   = (vaddr < PID_WINDOW) ? vaddr + pid_offset : vaddr;
    assign d1_src   = (st == W_L1_WAIT) ? mem_rsp_data : d1_q;
    assign perm_bad = (perm_status != '0);

    xlat_walk_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rsp_valid (mem_rsp_valid),
        .need_l2   (res_d.need_l2),
        .state     (st),
        .mem_req   (mem_req),
        .done      (done),
        .busy      (busy),
        .cap_start (cap_start),
        .cap_l1    (cap_l1),
        .cap_res   (cap_res)
    );

    xlat_addr_gen u_agen (
        .state (st),
        .base  (base_q),
        .va    (va_q),
        .d1    (d1_q),
        .addr  (mem_addr)
    );

    xlat_desc_decode u_dec (
        .va    (va_q),
        .d1    (d1_src),
        .d2    (mem_rsp_data),
        .at_l2 (st == W_L2_WAIT),
        .res   (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q         <= '0;
            base_q       <= '0;
            d1_q         <= '0;
            fetch_q      <= 1'b0;
            res_q        <= '0;
            fault_status <= '0;
            fault_addr   <= '0;
        end else begin
            if (cap_start) begin
                va_q    <= va_eff;
                base_q  <= table_base;
                fetch_q <= is_fetch;
            end
            if (cap_l1)  d1_q  <= mem_rsp_data;
            if (cap_res) res_q <= res_d;
            if (done && !fetch_q) begin
                if (res_q.fvalid) begin
                    fault_status <= res_q.fstat;
                    fault_addr   <= va_q;
                end else if (res_q.ok && perm_bad) begin
                    fault_status <= perm_status;
                    fault_addr   <= va_q;
                end
            end
        end
    end

    assign ok        = res_q.ok && !perm_bad;
    assign page_kind = res_q.kind;
    assign paddr     = res_q.paddr;
    assign domain    = res_q.domain;
    assign access    = res_q.access;
    assign tag       = res_q.tag;

    // R9 R11
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(done && !fetch_q) |=> ($stable(fault_status) && $stable(fault_addr)));

    // R12
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(va_q));

    // R6
    small_off_chk: assert property (@(posedge clk) disable iff (rst)
        (done && res_q.ok && res_q.kind == PG_SMALL) |-> (paddr[11:0] == va_q[11:0]));

    // R4 R6
    tag_page_chk: assert property (@(posedge clk) disable iff (rst)
        (done && res_q.ok) |-> (tag[31:20] == va_q[31:20]));

endmodule

// File: tb/test_xlat_table_walker.sv
`timescale 1ns/1ps
module test_xlat_table_walker;

    logic        clk = 1'b0, rst = 1'b1, start = 1'b0, is_fetch = 1'b0, rsp_v = 1'b0;
    logic [31:0] vaddr = '0, base = '0, pid = '0, rsp_d = '0;
    logic [7:0]  perm = '0;
    logic        mem_req, busy, done, ok;
    logic [31:0] mem_addr, paddr, tag, fault_addr;
    logic [1:0]  page_kind, access;
    logic [3:0]  domain;
    logic [7:0]  fault_status;

    int n_vec = 0, n_bad = 0;

    always #4 clk = ~clk;

    xlat_table_walker i_xlat_table_walker (
        .clk(clk), .rst(rst), .start(start), .vaddr(vaddr), .is_fetch(is_fetch),
        .table_base(base), .pid_offset(pid), .perm_status(perm),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d),
        .busy(busy), .done(done), .ok(ok), .page_kind(page_kind), .paddr(paddr),
        .domain(domain), .access(access), .tag(tag),
        .fault_status(fault_status), .fault_addr(fault_addr)
    );

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // expected values
    logic [31:0] e_va, e_a1, e_a2, e_pa, e_tag, h_fst, h_fa;
    int          e_reads;
    bit          e_xok, e_ok, e_fupd;
    logic [1:0]  e_kind, e_acc;
    logic [3:0]  e_dom;
    logic [7:0]  e_fst;
    string       rq_ok, rq_flt;

    task automatic model(input logic [31:0] va, b, p, d1, d2, input bit f, input logic [7:0] pm);
        e_va    = (va < 32'h0200_0000) ? va + p : va;
        e_a1    = {b[31:14], e_va[31:20], 2'b00};
        e_a2    = '0;
        e_reads = 1; e_xok = 0; e_fupd = 0; e_fst = '0;
        e_kind = '0; e_acc = '0; e_pa = '0; e_tag = '0;
        e_dom  = d1[8:5];
        rq_ok  = "R9";
        case (d1[1:0])
            2'd0: begin e_fupd = !f; e_fst = 8'h05; end
            2'd2: begin
                e_xok = 1; e_kind = 2'd0; rq_ok = "R4";
                e_pa  = {d1[31:20], e_va[19:0]};
                e_acc = d1[11:10];
                e_tag = {e_va[31:20], 20'h0};
            end
            default: begin
                e_reads = 2;
                e_a2 = (d1[1:0] == 2'd1) ? {d1[31:10], e_va[19:12], 2'b00}
                                         : {d1[31:12], e_va[19:10], 2'b00};
                case (d2[1:0])
                    2'd0: begin e_fupd = !f; e_fst = {d1[8:5], 4'h7}; end
                    2'd1: begin
                        e_xok = 1; e_kind = 2'd1; rq_ok = "R6";
                        e_pa  = {d2[31:16], e_va[15:0]};
                        e_tag = {e_va[31:12], 12'h0};
                        case (e_va[15:14])
                            2'd0: e_acc = d2[5:4];
                            2'd1: e_acc = d2[7:6];
                            2'd2: e_acc = d2[9:8];
                            default: e_acc = d2[11:10];
                        endcase
                    end
                    2'd2: begin
                        e_xok = 1; e_kind = 2'd2; rq_ok = "R6";
                        e_pa  = {d2[31:12], e_va[11:0]};
                        e_tag = {e_va[31:12], 12'h0};
                        case (e_va[11:10])
                            2'd0: e_acc = d2[5:4];
                            2'd1: e_acc = d2[7:6];
                            2'd2: e_acc = d2[9:8];
                            default: e_acc = d2[11:10];
                        endcase
                    end
                    default: begin
                        if (d1[1:0] == 2'd1) rq_ok = "R8";
                        else begin
                            e_xok = 1; e_kind = 2'd3; rq_ok = "R6";
                            e_pa  = {d2[31:10], e_va[9:0]};
                            e_acc = d2[5:4];
                            e_tag = {e_va[31:10], 10'h0};
                        end
                    end
                endcase
            end
        endcase
        if (e_xok && pm != 0) begin
            e_fupd = !f; e_fst = pm; rq_ok = "R10";
        end
        e_ok   = e_xok && (pm == 0);
        rq_flt = f ? "R11" : ((e_xok && pm != 0) ? "R10" : "R9");
        if (e_fupd) begin h_fst = {24'h0, e_fst}; h_fa = e_va; end
    endtask

    task automatic run_walk(input logic [31:0] va, b, p, d1, d2, input bit f,
                            input logic [7:0] pm, input bit glitch);
        int    nread = 0, wd = 0;
        bit    got = 0;
        string rqa;
        model(va, b, p, d1, d2, f, pm);
        @(negedge clk);
        vaddr = va; base = b; pid = p; is_fetch = f; perm = pm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got && wd < 60) begin
            if (done) got = 1;
            else if (mem_req) begin
                nread++;
                rqa = glitch ? "R12" : (va < 32'h0200_0000) ? "R2" : (nread == 1) ? "R3" : "R5";
                chk(rqa, "read address", mem_addr, (nread == 1) ? e_a1 : e_a2);
                if (glitch && nread == 1) begin start = 1'b1; vaddr = ~va; end
                repeat (1 + $urandom % 3) begin @(negedge clk); start = 1'b0; wd++; end
                rsp_v = 1'b1; rsp_d = (nread == 1) ? d1 : d2;
                @(negedge clk);
                rsp_v = 1'b0; rsp_d = $urandom;
            end else begin
                @(negedge clk); wd++;
            end
        end
        chk("R12", "walk completed", 32'(got), 32'd1);
        chk("R3", "read count", nread, e_reads);
        if (got) begin
            chk(rq_ok, "ok", 32'(ok), 32'(e_ok));
            if (e_xok) begin
                chk(rq_ok, "page kind", 32'(page_kind), 32'(e_kind));
                chk(rq_ok, "paddr", paddr, e_pa);
                chk(rq_ok, "tag", tag, e_tag);
                chk("R4", "domain", 32'(domain), 32'(e_dom));
                chk("R7", "access", 32'(access), 32'(e_acc));
            end
            @(negedge clk);
            chk("R12", "done one cycle", 32'(done), 32'd0);
            chk(rq_flt, "fault status", 32'(fault_status), h_fst);
            chk(rq_flt, "fault address", fault_addr, h_fa);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL R12 watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd7341));
        h_fst = '0; h_fa = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "mem_req", 32'(mem_req), 32'd0);
        chk("R1", "fault_status", 32'(fault_status), 32'd0);
        chk("R1", "fault_addr", fault_addr, 32'd0);

        // directed corners
        run_walk(32'h8765_4321, 32'h1234_5678, 32'h0, 32'hABC0_0D62, 32'h0, 0, 8'h00, 0);  // R4 section
        run_walk(32'h4012_3456, 32'h0000_8000, 32'h0, 32'h0000_0000, 32'h0, 0, 8'h00, 0);  // R9 L1 miss
        run_walk(32'h0012_3456, 32'h0000_8000, 32'h1000_0000, 32'h0000_0000, 32'h0, 1, 8'h00, 0); // R11 R2
        run_walk(32'h5013_0C00, 32'h0000_4000, 32'h0, 32'h0010_0401, 32'h7700_0E5A, 0, 8'h00, 0); // R7 small
        for (int k = 0; k < 4; k++)
            run_walk(32'h6020_0000 | (32'(k) << 14), 32'h0, 32'h0, 32'h0020_01E1, 32'h3300_0E45, 0, 8'h00, 0); // R7 large
        run_walk(32'h7031_23FF, 32'h0, 32'h0, 32'h0040_1063, 32'h9900_0433, 0, 8'h00, 0);  // R6 fine tiny
        run_walk(32'h7031_23FF, 32'h0, 32'h0, 32'h0040_1061, 32'h9900_0433, 0, 8'h00, 0);  // R8 coarse tiny
        run_walk(32'h7031_23FF, 32'h0, 32'h0, 32'h0040_11E3, 32'h9900_0430, 0, 8'h00, 0);  // R9 L2 miss
        run_walk(32'h9ABC_DEF0, 32'h0, 32'h0, 32'hFFF0_0C02, 32'h0, 0, 8'h0D, 0);          // R10
        run_walk(32'h9ABC_DEF0, 32'h0, 32'h0, 32'hFFF0_0C02, 32'h0, 1, 8'h0D, 0);          // R11
        run_walk(32'h3456_7890, 32'h0001_C000, 32'h0, 32'h1230_0002, 32'h0, 0, 8'h00, 1);  // R12 glitch
        run_walk(32'h01FF_FFFF, 32'h0, 32'h0200_0000, 32'h0, 32'h0, 0, 8'h00, 0);          // R2 edge
        run_walk(32'h0200_0000, 32'h0, 32'h0100_0000, 32'h0, 32'h0, 0, 8'h00, 0);          // R2 limit

        for (int n = 0; n < 300; n++) begin
            logic [31:0] va, b, p, d1, d2;
            logic [7:0]  pm;
            va = $urandom;
            if ($urandom % 4 == 0) va = va & 32'h01FF_FFFF;
            b = $urandom; p = $urandom; d1 = $urandom; d2 = $urandom;
            pm = ($urandom % 5 == 0) ? 8'($urandom) : 8'h00;
            run_walk(va, b, p, d1, d2, ($urandom % 3 == 0), pm, ($urandom % 8 == 0));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule